// File: doc/BRIEF.md
# Stop Mode Power Controller

This block puts a host processor core into a deep-sleep stop state and brings it back. Software sets a stop bit through a small register write port. From the next clock on, the block holds the gated-clock enable low, so the core, its timers and its serial ports all halt. The block itself runs on the always-on 32,768 Hz clock.

The clock-selection field is held untouched while the core sleeps, so a wake from an interrupt resumes at the frequency chosen before sleep. A reset restores that field to its default. Wake requests come in asynchronously and pass through a two-stage synchronizer on the slow clock. The gated clocks are released only after a qualified request has been registered there.

Entering stop also forces off the enable of a companion DSP core. That enable stays off after wake until software sets it again. A request for the low-power clock-divide mode is refused while a precision-timed operation is busy.

Top module: `stop_pwr_ctl`

## Requirements
- R1: After reset, sys_clk_en is 1, dsp_en_o is 0, slow_div_o is 0, clk_sel_o equals CLK_DEF (0), and every wake enable is 0.
- R2: A write to address 0 with bit 0 set, while no enabled wake source is registered, drives sys_clk_en low from the next clock. It stays low until a wake is accepted or reset is applied.
- R3: Address 1 bits [CLK_W-1:0] set clk_sel_o. Entering or leaving stop does not change clk_sel_o. Any register write made while sys_clk_en is low is ignored.
- R4: The wake sources are:
  - ext_irq[i], when address 2 bit i is set;
  - tod_alarm and subsec_alarm, always;
  - i2c_start, only when address 3 bit 0 (start interrupt enable) and bit 1 (bus enable) are both set;
  - svm_irq, when address 3 bit 2 is set.
  A source that is not enabled leaves the block stopped.
- R5: A wake input first sampled high at rising edge k sets sys_clk_en back to 1 after edge k+2.
- R6: A write to address 0 bit 1 sets dsp_en_o. Entering stop clears dsp_en_o, and it stays 0 after wake until software writes it to 1 again.
- R7: A stop write made while an enabled wake source is already registered never lowers sys_clk_en. The bit 1 value written with it is applied to dsp_en_o.
- R8: Address 0 bit 2 requests slow_div_o. Writing 1 while precise_busy is high leaves slow_div_o unchanged. Writing 0 always clears it.
- R9: Reset applied during stop returns sys_clk_en to 1 and clk_sel_o to CLK_DEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on 32 kHz domain clock |
| rst_n | input | 1 | Active-low asynchronous reset (includes the external reset pin) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 clock select, 2 external wake enables, 3 misc wake enables |
| wr_data | input | DATA_W | Register write data |
| ext_irq | input | N_EXT | External interrupt lines |
| tod_alarm | input | 1 | Time-of-day alarm |
| subsec_alarm | input | 1 | Subsecond alarm |
| i2c_start | input | 1 | I2C start-condition interrupt |
| svm_irq | input | 1 | Supply-voltage monitor interrupt |
| precise_busy | input | 1 | A precision-clocked operation (e.g. baud generation) is active |
| sys_clk_en | output | 1 | Enable for all gated clocks outside the 32 kHz domain |
| dsp_en_o | output | 1 | Companion DSP core enable |
| clk_sel_o | output | CLK_W | Clock-selection setting to the clock generator |
| slow_div_o | output | 1 | Low-power clock-divide mode |

## Verification
The hardest case to reach is a stop write that coincides with a wake source already sitting in the synchronizer. The stimulus holds the supply-monitor line high with its enable set for several clocks before issuing the stop write. It then confirms that the gated enable never drops for a single cycle.

A second hard case is a wake that arrives while the only pending source is masked. Here the bench pulses a disabled external line and an I2C start with only one of its two enables set. It then shows the block still stopped, before an enabled line brings it out.

// File: rtl/stop_pwr_ctl.sv
module stop_pwr_ctl #(
  parameter int N_EXT = 4,
  parameter int CLK_W = 3,
  parameter logic [CLK_W-1:0] CLK_DEF = '0,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic              tod_alarm,
  input  logic              subsec_alarm,
  input  logic              i2c_start,
  input  logic              svm_irq,
  input  logic              precise_busy,
  output logic              sys_clk_en,
  output logic              dsp_en_o,
  output logic [CLK_W-1:0]  clk_sel_o,
  output logic              slow_div_o
);
  localparam int SRC_W = N_EXT + 4;
  localparam int TOD_I = N_EXT;
  localparam int SUB_I = N_EXT + 1;
  localparam int I2C_I = N_EXT + 2;
  localparam int SVM_I = N_EXT + 3;

  logic [SRC_W-1:0] src_raw, sync1, sync2;
  logic             stop_q, dsp_q, slow_q;
  logic [CLK_W-1:0] clk_sel_q;
  logic [N_EXT-1:0] ext_en_q;
  logic             i2c_ie_q, i2c_on_q, svm_ie_q;
  logic             wake_now, wr_ok, ctrl_wr, stop_enter;

  assign src_raw = {svm_irq, i2c_start, subsec_alarm, tod_alarm, ext_irq};

  assign wake_now = (|(sync2[N_EXT-1:0] & ext_en_q))
                  | sync2[TOD_I] | sync2[SUB_I]
                  | (sync2[I2C_I] & i2c_ie_q & i2c_on_q)
                  | (sync2[SVM_I] & svm_ie_q);

  assign wr_ok      = wr_en & ~stop_q;
  assign ctrl_wr    = wr_ok && (wr_addr == 2'd0);
  assign stop_enter = ctrl_wr & wr_data[0] & ~wake_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= src_raw;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 stop_q <= 1'b0;
    else if (stop_q & wake_now) stop_q <= 1'b0;
    else if (stop_enter)        stop_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsp_q <= 1'b0;
      slow_q <= 1'b0;
    end else if (stop_enter) begin
      dsp_q <= 1'b0;
      if (!(wr_data[2] && precise_busy)) slow_q <= wr_data[2];
    end else if (ctrl_wr) begin
      dsp_q <= wr_data[1];
      if (!(wr_data[2] && precise_busy)) slow_q <= wr_data[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel_q <= CLK_DEF;
      ext_en_q  <= '0;
      i2c_ie_q  <= 1'b0;
      i2c_on_q  <= 1'b0;
      svm_ie_q  <= 1'b0;
    end else if (wr_ok) begin
      case (wr_addr)
        2'd1: clk_sel_q <= wr_data[CLK_W-1:0];
        2'd2: ext_en_q  <= wr_data[N_EXT-1:0];
        2'd3: begin
          i2c_ie_q <= wr_data[0];
          i2c_on_q <= wr_data[1];
          svm_ie_q <= wr_data[2];
        end
        default: ;
      endcase
    end
  end

  assign sys_clk_en = ~stop_q;
  assign dsp_en_o   = dsp_q;
  assign clk_sel_o  = clk_sel_q;
  assign slow_div_o = slow_q;

  assert_stop_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_clk_en) |-> $past(ctrl_wr && wr_data[0] && !wake_now));

  assert_wake_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_clk_en) |-> $past(wake_now));

  assert_clksel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_clk_en |=> $stable(clk_sel_o));

  assert_dsp_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_clk_en |-> !dsp_en_o);

  assert_no_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[0] && wake_now) |=> sys_clk_en);

  assert_slow_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[2] && precise_busy && !slow_div_o) |=> !slow_div_o);
endmodule

// File: tb/stop_pwr_ctl_tb.sv
module stop_pwr_ctl_tb;
  localparam int N_EXT = 4;
  localparam int CLK_W = 3;
  localparam int DATA_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [N_EXT-1:0] ext_irq = '0;
  logic tod_alarm = 0, subsec_alarm = 0, i2c_start = 0, svm_irq = 0, precise_busy = 0;
  logic sys_clk_en, dsp_en_o, slow_div_o;
  logic [CLK_W-1:0] clk_sel_o;

  int tests = 0, fails = 0;
  bit done = 0;

  stop_pwr_ctl #(.N_EXT(N_EXT), .CLK_W(CLK_W), .CLK_DEF('0), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_irq(ext_irq), .tod_alarm(tod_alarm), .subsec_alarm(subsec_alarm),
    .i2c_start(i2c_start), .svm_irq(svm_irq), .precise_busy(precise_busy),
    .sys_clk_en(sys_clk_en), .dsp_en_o(dsp_en_o), .clk_sel_o(clk_sel_o),
    .slow_div_o(slow_div_o));

  always #2 clk = ~clk;

  // behavioural reference model
  bit m_stop, m_dsp, m_slow, m_i2c_ie, m_i2c_on, m_svm_ie;
  int m_sel, m_ext_en;
  bit [7:0] d1, d2;  // two-sample delay lines for wake inputs

  always @(posedge clk) begin
    bit wake;
    if (!rst_n) begin
      m_stop = 0; m_dsp = 0; m_slow = 0; m_sel = 0; m_ext_en = 0;
      m_i2c_ie = 0; m_i2c_on = 0; m_svm_ie = 0; d1 = 0; d2 = 0;
    end else begin
      wake = ((d2[3:0] & m_ext_en[3:0]) != 0) || d2[4] || d2[5]
             || (d2[6] && m_i2c_ie && m_i2c_on) || (d2[7] && m_svm_ie);
      if (m_stop) begin
        if (wake) m_stop = 0;
      end else if (wr_en) begin
        case (wr_addr)
          0: begin
            if (wr_data[0] && !wake) begin m_stop = 1; m_dsp = 0; end
            else m_dsp = wr_data[1];
            if (!(wr_data[2] && precise_busy)) m_slow = wr_data[2];
          end
          1: m_sel = wr_data[2:0];
          2: m_ext_en = wr_data[3:0];
          default: begin m_i2c_ie = wr_data[0]; m_i2c_on = wr_data[1]; m_svm_ie = wr_data[2]; end
        endcase
      end
      d2 = d1;
      d1 = {svm_irq, i2c_start, subsec_alarm, tod_alarm, ext_irq};
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(sys_clk_en == !m_stop, "R2/R4/R5 sys_clk_en vs model", sys_clk_en, !m_stop);
    chk(dsp_en_o == m_dsp, "R6 dsp_en_o vs model", dsp_en_o, m_dsp);
    chk(clk_sel_o == m_sel, "R3 clk_sel_o vs model", clk_sel_o, m_sel);
    chk(slow_div_o == m_slow, "R8 slow_div_o vs model", slow_div_o, m_slow);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; idle(3); rst_n = 1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; @(negedge clk);
    chk(sys_clk_en && !dsp_en_o && !slow_div_o && clk_sel_o == 0, "R1 reset state",
        {sys_clk_en, dsp_en_o, slow_div_o, clk_sel_o}, 6'b100000);

    wr(1, 5); wr(2, 8'b0010); wr(0, 2);
    chk(dsp_en_o == 1, "R6 dsp enable write", dsp_en_o, 1);
    // enter stop: wr task returns one negedge after the write edge
    wr(0, 8'h03);
    chk(sys_clk_en == 0, "R2 stop entered", sys_clk_en, 0);
    chk(dsp_en_o == 0, "R6 dsp forced off", dsp_en_o, 0);
    wr(1, 2);
    chk(clk_sel_o == 5, "R3 write ignored in stop", clk_sel_o, 5);
    // disabled ext line
    @(negedge clk); ext_irq = 4'b0001; @(negedge clk); ext_irq = 0; idle(4);
    chk(sys_clk_en == 0, "R4 disabled line no wake", sys_clk_en, 0);
    // enabled line: sampled at edge k, clocks back after edge k+2
    @(negedge clk); ext_irq = 4'b0010; @(negedge clk); ext_irq = 0;
    chk(sys_clk_en == 0, "R5 after edge k", sys_clk_en, 0);
    @(negedge clk);
    chk(sys_clk_en == 0, "R5 after edge k+1", sys_clk_en, 0);
    @(negedge clk);
    chk(sys_clk_en == 1, "R5 after edge k+2", sys_clk_en, 1);
    chk(clk_sel_o == 5, "R3 clk_sel kept over stop", clk_sel_o, 5);
    chk(dsp_en_o == 0, "R6 dsp stays off after wake", dsp_en_o, 0);

    // alarm wake
    wr(0, 1);
    @(negedge clk); subsec_alarm = 1; @(negedge clk); subsec_alarm = 0; idle(3);
    chk(sys_clk_en == 1, "R4 subsecond alarm wake", sys_clk_en, 1);
    wr(0, 1);
    @(negedge clk); tod_alarm = 1; @(negedge clk); tod_alarm = 0; idle(3);
    chk(sys_clk_en == 1, "R4 tod alarm wake", sys_clk_en, 1);

    // i2c needs both enables
    wr(3, 1); wr(0, 1);
    @(negedge clk); i2c_start = 1; @(negedge clk); i2c_start = 0; idle(4);
    chk(sys_clk_en == 0, "R4 i2c half enabled", sys_clk_en, 0);
    @(negedge clk); svm_irq = 1; @(negedge clk); svm_irq = 0; idle(4);
    chk(sys_clk_en == 0, "R4 svm disabled", sys_clk_en, 0);
    do_reset;
    chk(sys_clk_en == 1 && clk_sel_o == 0, "R9 reset ends stop", {sys_clk_en, clk_sel_o}, 4'b1000);

    wr(1, 6); wr(3, 3); wr(0, 1);
    @(negedge clk); i2c_start = 1; @(negedge clk); i2c_start = 0; idle(3);
    chk(sys_clk_en == 1, "R4 i2c fully enabled wake", sys_clk_en, 1);
    wr(3, 4); wr(0, 1);
    @(negedge clk); svm_irq = 1; @(negedge clk); svm_irq = 0; idle(3);
    chk(sys_clk_en == 1, "R4 svm wake", sys_clk_en, 1);

    // pre-pending wake
    @(negedge clk); svm_irq = 1; idle(3);
    wr(0, 8'h03);
    chk(sys_clk_en == 1, "R7 pending wake blocks stop", sys_clk_en, 1);
    chk(dsp_en_o == 1, "R7 dsp written bit applied", dsp_en_o, 1);
    svm_irq = 0; idle(3);

    // slow divide
    precise_busy = 1; wr(0, 4);
    chk(slow_div_o == 0, "R8 set rejected while busy", slow_div_o, 0);
    precise_busy = 0; wr(0, 4);
    chk(slow_div_o == 1, "R8 set accepted", slow_div_o, 1);
    precise_busy = 1; wr(0, 0);
    chk(slow_div_o == 0, "R8 clear always accepted", slow_div_o, 0);
    precise_busy = 0;

    // reset mid-stop
    wr(1, 7); wr(0, 1); idle(2);
    do_reset;
    @(negedge clk);
    chk(sys_clk_en == 1 && clk_sel_o == 0, "R9 clk_sel default after reset",
        {sys_clk_en, clk_sel_o}, 4'b1000);
    idle(5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule